// File: doc/BRIEF.md
# Core-Voltage Command Port with Two-Wire Slave and Static Code Fallback

This block sits between a host processor and the reference DAC of a core-voltage regulator. It holds one command: a 4-bit voltage code and a 2-bit transition slew code. A host can write that command over a two-wire (I2C) bus with 7-bit addressing, and can read it back. A written byte only takes effect on the rising clock edge of its acknowledge bit, so a transfer that is cut short never changes the regulator target.

A static-mode pin takes both bus lines away from the serial protocol. In that mode the clock line, the data line and two extra pins form a 4-bit voltage code directly, and the slew code is pinned to a fixed default. The stored command survives static mode untouched and comes back when the pin returns low. Every pin passes through the same synchroniser depth, so both modes have the same latency.

The protocol engine is a state machine. Its states are IDLE (bus free or not addressed), ADDR (shift in address and direction), ADDR_ACK (pull data low for the address), WR_BYTE (shift in a command byte), WR_ACK (pull data low, commit on the rising clock), RD_BYTE (drive the command out MSB first) and RD_ACK (sample the master's acknowledge). The transitions are: START from any state goes to ADDR; STOP from any state goes to IDLE; static mode from any state goes to IDLE. ADDR goes to ADDR_ACK after eight bits that match the address, and to IDLE after eight bits that do not. ADDR_ACK goes to RD_BYTE (read) or WR_BYTE (write). WR_BYTE goes to WR_ACK after eight bits, and WR_ACK goes back to WR_BYTE. RD_BYTE goes to RD_ACK after eight bits. RD_ACK goes to RD_BYTE on an acknowledge, or to IDLE on a not-acknowledge.

Top module: `vcmd_i2c_port`

## Requirements
- R1: The slave answers only to address 7'b0001100 (first seven bits of the first byte, MSB first; eighth bit 0 = write, 1 = read). On a match it pulls SDA low through the ninth clock. On a mismatch it drives nothing and acknowledges no further byte until the next START, and the command is unchanged.
- R2: In a written byte, bits [3:0] become the voltage code and bits [5:4] the slew code; bits [7:6] are ignored. Each written byte is acknowledged, and it takes effect on the synchronised rising SCL edge of its acknowledge bit.
- R3: After one write address, any number of data bytes may follow; each one is acknowledged and applied in turn.
- R4: `update_o` is high for exactly one clock for each applied byte, in the same cycle that the new code first appears on the outputs.
- R5: A read returns the byte {2'b00, slew[1:0], vcode[3:0]} MSB first. A master not-acknowledge ends the read, and SDA is released.
- R6: After reset the voltage code is 4'b1001 and the slew code is 2'b01.
- R7: A START in any state, including a repeated START or one in the middle of a byte, restarts address reception. A STOP in any state returns to IDLE without changing the command.
- R8: While the static pin is high, `vcode_o` = {vid3, vid2, SDA pin, SCL pin}, `slew_o` = 2'b01, SDA is never pulled, and bus activity is ignored.
- R9: The stored command is retained through static mode and appears again on the outputs when the pin returns low.
- R10: The SDA pull changes only while the synchronised SCL is low.
- R11: Every input pin passes through three clock stages: an output responds at the third rising clock edge after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_vid0_i | input | 1 | Bus clock, or voltage bit 0 in static mode |
| sda_vid1_i | input | 1 | Bus data line level, or voltage bit 1 in static mode |
| vid2_i | input | 1 | Voltage bit 2 in static mode |
| vid3_i | input | 1 | Voltage bit 3 in static mode |
| static_sel_i | input | 1 | High selects static pin mode |
| sda_pull_o | output | 1 | High pulls the open-drain SDA line low |
| vcode_o | output | 4 | Active voltage code |
| slew_o | output | 2 | Active slew code |
| update_o | output | 1 | One-clock strobe when a written byte is applied |

## Verification
Every pin reaches the outputs at the third rising clock edge after it changes, whichever mode is active. The bench therefore records its intended code, slew and strobe at each rising edge, and compares the outputs on every falling edge with the entry recorded three edges earlier. Acknowledge and read-data bits are sampled at the last clock before SCL falls, long after the slave's three-cycle reaction to the previous falling SCL edge. Scenario checks are taken only once the pipeline has settled, several cycles after a STOP or a pin change.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned VCODE_W   = 4;
    localparam int unsigned SLEW_W    = 2;
    localparam int unsigned CMD_W     = VCODE_W + SLEW_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_t;
endpackage

// File: rtl/vcmd_pin_sync.sv
module vcmd_pin_sync #(
    parameter int unsigned       WIDTH   = 2,
    parameter int unsigned       DEPTH   = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] q_o
);
    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {DEPTH{RST_VAL}};
                else        chain_q <= pins_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {DEPTH{RST_VAL}};
                else        chain_q <= {chain_q[DEPTH-2:0], pins_i};
            end
        end
    endgenerate

    assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/vcmd_link_fsm.sv
module vcmd_link_fsm
    import vcmd_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b0001100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold_i,
    input  logic                 scl_cur_i,
    input  logic                 scl_prev_i,
    input  logic                 sda_cur_i,
    input  logic                 sda_prev_i,
    input  logic [BYTE_BITS-1:0] rd_byte_i,
    output logic [CMD_W-1:0]     wr_data_o,
    output logic                 wr_fire_o,
    output logic                 sda_pull_o
);
    localparam int unsigned          CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0]     FULL  = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0]     LAST  = CNT_W'(BYTE_BITS - 1);

    link_state_t          state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_BITS-1:0] shift_q;
    logic                 rnw_q;

    logic scl_rise, scl_fall, bus_start, bus_stop;

    always_comb begin
        scl_rise  = scl_cur_i & ~scl_prev_i;
        scl_fall  = ~scl_cur_i & scl_prev_i;
        bus_start = scl_cur_i & scl_prev_i & sda_prev_i & ~sda_cur_i;
        bus_stop  = scl_cur_i & scl_prev_i & ~sda_prev_i & sda_cur_i;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            rnw_q   <= 1'b0;
        end else if (hold_i) begin
            state_q <= ST_IDLE;
        end else if (bus_start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
        end else if (bus_stop) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shift_q <= {shift_q[BYTE_BITS-2:0], sda_cur_i};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL) begin
                        if (shift_q[BYTE_BITS-1:1] == SLAVE_ADDR) begin
                            state_q <= ST_ADDR_ACK;
                            rnw_q   <= shift_q[0];
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rnw_q) begin
                            state_q <= ST_RD_BYTE;
                            shift_q <= rd_byte_i;
                        end else begin
                            state_q <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shift_q <= {shift_q[BYTE_BITS-2:0], sda_cur_i};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL) begin
                        state_q <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_q <= ST_WR_BYTE;
                        cnt_q   <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shift_q <= {shift_q[BYTE_BITS-2:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == LAST) state_q <= ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise && sda_cur_i) begin
                        state_q <= ST_IDLE;
                    end else if (scl_fall) begin
                        state_q <= ST_RD_BYTE;
                        cnt_q   <= '0;
                        shift_q <= rd_byte_i;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_data_o  = shift_q[CMD_W-1:0];
        wr_fire_o  = !hold_i && !bus_start && !bus_stop
                     && state_q == ST_WR_ACK && scl_rise;
        sda_pull_o = !hold_i && (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK
                     || (state_q == ST_RD_BYTE && !shift_q[BYTE_BITS-1]));
    end
endmodule

// File: rtl/vcmd_i2c_port.sv
module vcmd_i2c_port
    import vcmd_pkg::*;
#(
    parameter logic [6:0]  SLAVE_ADDR  = 7'b0001100,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  RESET_VCODE = 4'b1001,
    parameter logic [1:0]  RESET_SLEW  = 2'b01,
    parameter logic [1:0]  STATIC_SLEW = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_vid0_i,
    input  logic       sda_vid1_i,
    input  logic       vid2_i,
    input  logic       vid3_i,
    input  logic       static_sel_i,
    output logic       sda_pull_o,
    output logic [3:0] vcode_o,
    output logic [1:0] slew_o,
    output logic       update_o
);
    localparam int unsigned BUS_W  = 2;
    localparam int unsigned AUX_W  = 3;
    localparam int unsigned B_SCL  = 0;
    localparam int unsigned B_SDA  = 1;
    localparam int unsigned A_V2   = 0;
    localparam int unsigned A_V3   = 1;
    localparam int unsigned A_MODE = 2;

    logic [BUS_W-1:0] bus_cur, bus_prev;
    logic [AUX_W-1:0] aux_q;
    logic             static_q, scl_cur;
    logic [CMD_W-1:0] cmd_q, wr_data;
    logic             upd_q, wr_fire;

    vcmd_pin_sync #(.WIDTH(BUS_W), .DEPTH(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .pins_i({sda_vid1_i, scl_vid0_i}), .q_o(bus_cur)
    );

    vcmd_pin_sync #(.WIDTH(AUX_W), .DEPTH(SYNC_STAGES + 1), .RST_VAL(3'b000)) u_aux_sync (
        .clk(clk), .rst_n(rst_n),
        .pins_i({static_sel_i, vid3_i, vid2_i}), .q_o(aux_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_prev <= 2'b11;
        else        bus_prev <= bus_cur;
    end

    assign static_q = aux_q[A_MODE];
    assign scl_cur  = bus_cur[B_SCL];

    vcmd_link_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .hold_i(static_q),
        .scl_cur_i(scl_cur), .scl_prev_i(bus_prev[B_SCL]),
        .sda_cur_i(bus_cur[B_SDA]), .sda_prev_i(bus_prev[B_SDA]),
        .rd_byte_i({{(BYTE_BITS-CMD_W){1'b0}}, cmd_q}),
        .wr_data_o(wr_data), .wr_fire_o(wr_fire), .sda_pull_o(sda_pull_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= {RESET_SLEW, RESET_VCODE};
            upd_q <= 1'b0;
        end else begin
            upd_q <= wr_fire;
            if (wr_fire) cmd_q <= wr_data;
        end
    end

    always_comb begin
        update_o = upd_q;
        if (static_q) begin
            vcode_o = {aux_q[A_V3], aux_q[A_V2], bus_prev[B_SDA], bus_prev[B_SCL]};
            slew_o  = STATIC_SLEW;
        end else begin
            vcode_o = cmd_q[VCODE_W-1:0];
            slew_o  = cmd_q[CMD_W-1:VCODE_W];
        end
    end
endmodule

// File: rtl/vcmd_i2c_port_chk.sv
module vcmd_i2c_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       static_q,
    input logic       scl_c,
    input logic       sda_pull_o,
    input logic       update_o,
    input logic [3:0] vcode_o,
    input logic [1:0] slew_o
);
    // R4: the strobe lasts a single clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R2: a byte is applied only while the slave was holding its acknowledge
    a_r2_commit_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> $past(sda_pull_o));

    // R8: no byte is applied in the cycle after static mode is seen
    a_r8_static_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        static_q |=> !update_o);

    // R9: outside static mode, the outputs move only with the strobe
    a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_q && !$past(static_q) && !update_o) |-> ($stable(vcode_o) && $stable(slew_o)));

    // R10: the SDA pull changes only while the synchronised SCL is low
    a_r10_sda_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_q && !$past(static_q) && !$stable(sda_pull_o)) |-> !scl_c);
endmodule

bind vcmd_i2c_port vcmd_i2c_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .static_q(static_q), .scl_c(scl_cur),
    .sda_pull_o(sda_pull_o), .update_o(update_o),
    .vcode_o(vcode_o), .slew_o(slew_o)
);

// File: tb/vcmd_i2c_port_test.sv
module vcmd_i2c_port_test;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, vid2 = 1'b0, vid3 = 1'b0, mode = 1'b0;
    logic sda_pull, update;
    logic [3:0] vcode;
    logic [1:0] slew;
    logic sda_line;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    vcmd_i2c_port uut (
        .clk(clk), .rst_n(rst_n), .scl_vid0_i(scl_m), .sda_vid1_i(sda_line),
        .vid2_i(vid2), .vid3_i(vid3), .static_sel_i(mode),
        .sda_pull_o(sda_pull), .vcode_o(vcode), .slew_o(slew), .update_o(update)
    );

    int n_chk = 0, n_fail = 0, upd_seen = 0;
    bit ended = 1'b0, mon_on = 1'b0;
    logic [5:0] cmd_m = 6'h19;
    logic upd_int = 1'b0;
    logic [6:0] hist[$];
    logic pull_s = 1'b0, scl_s = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // reference: intent per rising edge, due at the outputs three edges later (R11)
    initial repeat (3) hist.push_back({1'b0, cmd_m});
    always @(posedge clk) begin
        hist.push_back(mode ? {upd_int, 2'b01, vid3, vid2, sda_m, scl_m} : {upd_int, cmd_m});
        if (hist.size() > 3) void'(hist.pop_front());
        pull_s <= sda_pull;
        scl_s  <= scl_m;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk({slew, vcode} == hist[0][5:0], "R11 outputs", {slew, vcode}, hist[0][5:0]);
            chk(update == hist[0][6], "R4 strobe", update, hist[0][6]);
            if (sda_pull != pull_s && scl_s && !mode)
                chk(1'b0, "R10 pull moved with SCL high", sda_pull, pull_s);
            if (update) upd_seen++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic half(); repeat (HALF) @(negedge clk); endtask

    task automatic m_start();
        sda_m = 1'b0; half(); scl_m = 1'b0;
    endtask

    task automatic m_restart();
        sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; half(); scl_m = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        b = sda_line;
        @(negedge clk) scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit apply, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        sda_m = 1'b1; half(); scl_m = 1'b1;
        if (apply) begin
            cmd_m = d[5:0];
            upd_int = 1'b1;
        end
        @(negedge clk) upd_int = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        ack = sda_line;
        @(negedge clk) scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            m_bit_r(b);
            d[i] = b;
        end
        m_bit_w(nack);
    endtask

    initial begin
        logic ack;
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        repeat (4) @(negedge clk);
        chk(vcode == 4'b1001, "R6 reset vcode", vcode, 4'b1001);
        chk(slew == 2'b01, "R6 reset slew", slew, 2'b01);
        chk(update == 1'b0, "R6 reset strobe", update, 0);

        // read of the reset command
        m_start(); send_byte(8'h19, 1'b0, ack);
        chk(ack == 1'b0, "R1 read address ack", ack, 0);
        recv_byte(rd, 1'b1);
        chk(rd == 8'h19, "R5 read data", rd, 8'h19);
        m_stop(); repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0, "R5 released after NACK", sda_pull, 0);

        // single write, upper bits ignored
        m_start(); send_byte(8'h18, 1'b0, ack);
        chk(ack == 1'b0, "R1 write address ack", ack, 0);
        send_byte(8'hE3, 1'b1, ack);
        chk(ack == 1'b0, "R2 data ack", ack, 0);
        m_stop(); repeat (5) @(negedge clk);
        chk(vcode == 4'h3, "R2 vcode", vcode, 4'h3);
        chk(slew == 2'h2, "R2 slew", slew, 2'h2);

        // two bytes in one transfer
        upd_seen = 0;
        m_start(); send_byte(8'h18, 1'b0, ack);
        send_byte(8'h05, 1'b1, ack);
        chk(ack == 1'b0, "R3 first byte ack", ack, 0);
        send_byte(8'h3A, 1'b1, ack);
        chk(ack == 1'b0, "R3 second byte ack", ack, 0);
        m_stop(); repeat (5) @(negedge clk);
        chk({slew, vcode} == 6'h3A, "R3 last byte applied", {slew, vcode}, 6'h3A);
        chk(upd_seen == 2, "R4 one strobe per byte", upd_seen, 2);

        // wrong address
        m_start(); send_byte(8'h1A, 1'b0, ack);
        chk(ack == 1'b1, "R1 mismatch not acked", ack, 1);
        send_byte(8'h00, 1'b0, ack);
        chk(ack == 1'b1, "R1 data after mismatch not acked", ack, 1);
        m_stop(); repeat (5) @(negedge clk);
        chk({slew, vcode} == 6'h3A, "R1 mismatch left command", {slew, vcode}, 6'h3A);

        // write, repeated start, read back
        m_start(); send_byte(8'h18, 1'b0, ack);
        send_byte(8'h0F, 1'b1, ack);
        m_restart(); send_byte(8'h19, 1'b0, ack);
        chk(ack == 1'b0, "R7 repeated start address ack", ack, 0);
        recv_byte(rd, 1'b1);
        chk(rd == 8'h0F, "R7 read after repeated start", rd, 8'h0F);
        m_stop();

        // stop in the middle of a byte
        m_start(); send_byte(8'h18, 1'b0, ack);
        m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1);
        m_stop(); repeat (5) @(negedge clk);
        chk({slew, vcode} == 6'h0F, "R7 partial byte dropped", {slew, vcode}, 6'h0F);

        // static mode
        mode = 1'b1; repeat (6) @(negedge clk);
        sda_m = 1'b0; vid2 = 1'b1; vid3 = 1'b1; repeat (6) @(negedge clk);
        chk(vcode == 4'hD, "R8 static code", vcode, 4'hD);
        chk(slew == 2'b01, "R8 static slew", slew, 2'b01);
        vid2 = 1'b0; vid3 = 1'b0; sda_m = 1'b1; scl_m = 1'b0; repeat (6) @(negedge clk);
        chk(vcode == 4'h2, "R8 static code 2", vcode, 4'h2);
        scl_m = 1'b1; sda_m = 1'b1; repeat (4) @(negedge clk);
        m_start(); send_byte(8'h18, 1'b0, ack);
        chk(ack == 1'b1, "R8 bus ignored", ack, 1);
        send_byte(8'h22, 1'b0, ack);
        chk(ack == 1'b1, "R8 byte ignored", ack, 1);
        m_stop(); repeat (4) @(negedge clk);
        mode = 1'b0; repeat (6) @(negedge clk);
        chk({slew, vcode} == 6'h0F, "R9 command retained", {slew, vcode}, 6'h0F);

        // normal write after static mode
        m_start(); send_byte(8'h18, 1'b0, ack);
        send_byte(8'h16, 1'b1, ack);
        chk(ack == 1'b0, "R2 ack after static", ack, 0);
        m_stop(); repeat (5) @(negedge clk);
        chk({slew, vcode} == 6'h16, "R2 write after static", {slew, vcode}, 6'h16);

        finish_run();
    end
endmodule